// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wakeup

This block counts down a number of seconds loaded by software. A register write loads a 32-bit seconds value. From then on, while counting is enabled, the remaining count drops by one on every cycle in which the seconds tick input is high. When the count steps from one to zero, a pending flag is set and the count stays at zero. Software clears the flag by writing a one to its bit.

The pending flag drives two outputs, each through its own gate. The interrupt line is the pending flag ANDed with an interrupt-enable bit. The wakeup line is the pending flag ANDed with a wakeup-configuration bit.

A second, weekly alarm has no time comparison inside this block. It consists only of an enable bit, an interrupt-enable bit and a write-one-to-clear status bit. The status bit is set by an external match pulse, and the weekly alarm shares the interrupt line with the countdown.

Software reaches the block through a simple synchronous register port: write strobe, byte address and write data. Read data is returned combinationally from the current address. The reset input is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `sec_alarm`

## Requirements
- R1: After reset, every mapped register reads 0, and irq_o and wake_o are low.
- R2: A write to offset 0x20 loads the seconds count. The loaded value reads back at 0x20, and the same value is the remaining count at 0x24. A write to 0x24 has no effect.
- R3: While bit 0 of offset 0x28 is 1 and the remaining count is nonzero, the count decreases by exactly one per cycle in which tick is high. With the bit at 0, or with tick low, the count holds.
- R4: When the count steps from 1 to 0, bit 0 of offset 0x30 (pending) becomes 1 on that same edge. Further ticks leave the count at 0.
- R5: Loading 0, or clearing the enable bit, stops the countdown without setting pending.
- R6: Writing 1 to bit 0 of 0x30 clears pending, and writing 0 there has no effect. If an expiry and a clearing write fall in the same cycle, pending stays set.
- R7: irq_o is high when the pending bit at 0x30 is 1 and bit 0 of 0x2C is 1, or when the weekly status bit at 0x4C is 1 and bit 0 of 0x48 is 1.
- R8: wake_o equals the pending bit at 0x30 ANDed with bit 0 of 0x50. The weekly alarm does not drive it.
- R9: A wk_hit pulse sets bit 0 of 0x4C only when bit 0 of 0x44 is 1. Writing 1 to bit 0 of 0x4C clears it.
- R10: A load write that falls in a tick cycle takes precedence: the remaining count becomes the written value and is not decremented.
- R11: The control registers 0x28, 0x2C, 0x44, 0x48 and 0x50 store only bit 0, and their other bits read 0. Unmapped offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse for each elapsed second |
| wk_hit_i | input | 1 | Weekly match pulse from the surrounding logic |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Gated alarm interrupt |
| wake_o | output | 1 | Gated countdown wakeup |

## Verification
Some collisions can only be produced by driving two inputs in the same clock edge. One is a load write that lands on a tick cycle. Another is a write-one-to-clear that lands on the very tick that takes the count from one to zero. A plain sequence of register writes never lines these up, so the directed phase forces each pairing on purpose.

The random phase keeps loaded values between 0 and 5. This makes expiries, zero loads and enable toggles meet one another often. The collisions then recur in many orderings, and every step is checked against a bench model of the count and the flags.

// File: rtl/sec_alarm_pkg.sv
`timescale 1ns/1ps
package sec_alarm_pkg;

  // Byte offsets of the software-visible registers
  localparam logic [7:0] OFS_LOAD   = 8'h20;
  localparam logic [7:0] OFS_LEFT   = 8'h24;
  localparam logic [7:0] OFS_CEN    = 8'h28;
  localparam logic [7:0] OFS_CIE    = 8'h2C;
  localparam logic [7:0] OFS_CSTAT  = 8'h30;
  localparam logic [7:0] OFS_WEN    = 8'h44;
  localparam logic [7:0] OFS_WIE    = 8'h48;
  localparam logic [7:0] OFS_WSTAT  = 8'h4C;
  localparam logic [7:0] OFS_WAKE   = 8'h50;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_CNT  = 0;
  localparam int FLAG_WK   = 1;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LOAD, SEL_LEFT, SEL_CEN, SEL_CIE, SEL_CSTAT,
    SEL_WEN, SEL_WIE, SEL_WSTAT, SEL_WAKE
  } reg_sel_e;

  typedef struct packed {
    logic cnt_en;
    logic cnt_ie;
    logic wk_en;
    logic wk_ie;
    logic wake_cfg;
  } ctl_bits_t;

  typedef struct packed {
    logic ld;
    logic cnt_clr;
    logic wk_clr;
  } strobes_t;

endpackage

// File: rtl/sec_alarm_flag.sv
`timescale 1ns/1ps
module sec_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_q;
  logic q_we;

  // set has priority over a clearing write in the same cycle
  always_comb begin
    q_we = set_i | clr_i;
    q_d  = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_q <= 1'b0;
    else if (q_we)  q_q <= q_d;
  end

  assign q_o = q_q;

  // R4
  set_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/sec_alarm_cnt.sv
`timescale 1ns/1ps
module sec_alarm_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  output logic [CNT_W-1:0] left_o,
  output logic [CNT_W-1:0] ld_val_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] left_d, left_q;
  logic [CNT_W-1:0] ldv_q;
  logic             dec_en;
  logic             left_we;

  always_comb begin
    dec_en   = run_i & tick_i & (left_q != ZERO) & ~ld_i;
    left_we  = ld_i | dec_en;
    left_d   = left_q;
    expire_o = 1'b0;
    if (ld_i) begin
      left_d = ld_data_i;
    end else if (dec_en) begin
      left_d   = left_q - ONE;
      expire_o = (left_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= ZERO;
    else if (left_we) left_q <= left_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ldv_q <= ZERO;
    else if (ld_i) ldv_q <= ld_data_i;
  end

  assign left_o   = left_q;
  assign ld_val_o = ldv_q;

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (left_o == $past(ld_data_i)));
  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && run_i && tick_i && left_o != ZERO) |=> (left_o == $past(left_o) - ONE));
  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && left_o == ZERO) |=> (left_o == ZERO));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !(run_i && tick_i)) |=> $stable(left_o));

endmodule

// File: rtl/sec_alarm_regs.sv
`timescale 1ns/1ps
module sec_alarm_regs
  import sec_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [CNT_W-1:0]     left_i,
  input  logic [CNT_W-1:0]     ld_val_i,
  input  logic [NUM_FLAGS-1:0] pend_i,
  output ctl_bits_t            ctl_o,
  output strobes_t             strb_o,
  output logic [CNT_W-1:0]     ld_data_o,
  output logic [DATA_W-1:0]    rdata_o
);
  reg_sel_e  sel;
  ctl_bits_t ctl_d, ctl_q;
  logic      ctl_we;

  always_comb begin
    sel = SEL_NONE;
    if      (addr_i == ADDR_W'(OFS_LOAD))  sel = SEL_LOAD;
    else if (addr_i == ADDR_W'(OFS_LEFT))  sel = SEL_LEFT;
    else if (addr_i == ADDR_W'(OFS_CEN))   sel = SEL_CEN;
    else if (addr_i == ADDR_W'(OFS_CIE))   sel = SEL_CIE;
    else if (addr_i == ADDR_W'(OFS_CSTAT)) sel = SEL_CSTAT;
    else if (addr_i == ADDR_W'(OFS_WEN))   sel = SEL_WEN;
    else if (addr_i == ADDR_W'(OFS_WIE))   sel = SEL_WIE;
    else if (addr_i == ADDR_W'(OFS_WSTAT)) sel = SEL_WSTAT;
    else if (addr_i == ADDR_W'(OFS_WAKE))  sel = SEL_WAKE;
  end

  always_comb begin
    ctl_d  = ctl_q;
    ctl_we = 1'b0;
    if (wr_i) begin
      case (sel)
        SEL_CEN:  begin ctl_d.cnt_en   = wdata_i[0]; ctl_we = 1'b1; end
        SEL_CIE:  begin ctl_d.cnt_ie   = wdata_i[0]; ctl_we = 1'b1; end
        SEL_WEN:  begin ctl_d.wk_en    = wdata_i[0]; ctl_we = 1'b1; end
        SEL_WIE:  begin ctl_d.wk_ie    = wdata_i[0]; ctl_we = 1'b1; end
        SEL_WAKE: begin ctl_d.wake_cfg = wdata_i[0]; ctl_we = 1'b1; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  always_comb begin
    strb_o.ld      = wr_i && (sel == SEL_LOAD);
    strb_o.cnt_clr = wr_i && (sel == SEL_CSTAT) && wdata_i[0];
    strb_o.wk_clr  = wr_i && (sel == SEL_WSTAT) && wdata_i[0];
  end

  assign ctl_o     = ctl_q;
  assign ld_data_o = CNT_W'(wdata_i);

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_LOAD:  rdata_o = DATA_W'(ld_val_i);
      SEL_LEFT:  rdata_o = DATA_W'(left_i);
      SEL_CEN:   rdata_o = DATA_W'(ctl_q.cnt_en);
      SEL_CIE:   rdata_o = DATA_W'(ctl_q.cnt_ie);
      SEL_CSTAT: rdata_o = DATA_W'(pend_i[FLAG_CNT]);
      SEL_WEN:   rdata_o = DATA_W'(ctl_q.wk_en);
      SEL_WIE:   rdata_o = DATA_W'(ctl_q.wk_ie);
      SEL_WSTAT: rdata_o = DATA_W'(pend_i[FLAG_WK]);
      SEL_WAKE:  rdata_o = DATA_W'(ctl_q.wake_cfg);
      default:   rdata_o = '0;
    endcase
  end

  // R11
  ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctl_o));

endmodule

// File: rtl/sec_alarm.sv
`timescale 1ns/1ps
module sec_alarm
  import sec_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wk_hit_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]    rst_sq;
  logic                 rst_sn;
  ctl_bits_t            ctl;
  strobes_t             strb;
  logic [CNT_W-1:0]     ld_data, left, ld_val;
  logic                 expire;
  logic [NUM_FLAGS-1:0] pend, flag_set, flag_clr;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[SYNC_N-2:0], 1'b1};
  end
  assign rst_sn = rst_sq[SYNC_N-1];

  sec_alarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_sn), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .left_i(left), .ld_val_i(ld_val), .pend_i(pend),
    .ctl_o(ctl), .strb_o(strb), .ld_data_o(ld_data), .rdata_o(bus_rdata_o)
  );

  sec_alarm_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick_i), .run_i(ctl.cnt_en),
    .ld_i(strb.ld), .ld_data_i(ld_data), .left_o(left), .ld_val_o(ld_val),
    .expire_o(expire)
  );

  always_comb begin
    flag_set[FLAG_CNT] = expire;
    flag_clr[FLAG_CNT] = strb.cnt_clr;
    flag_set[FLAG_WK]  = wk_hit_i & ctl.wk_en;
    flag_clr[FLAG_WK]  = strb.wk_clr;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sec_alarm_flag flag_i (
      .clk(clk), .rst_n(rst_sn), .set_i(flag_set[g]), .clr_i(flag_clr[g]),
      .q_o(pend[g])
    );
  end

  assign irq_o  = (pend[FLAG_CNT] & ctl.cnt_ie) | (pend[FLAG_WK] & ctl.wk_ie);
  assign wake_o = pend[FLAG_CNT] & ctl.wake_cfg;

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    wake_o |-> pend[FLAG_CNT]);
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_o |-> (pend != '0));
  // R9
  wk_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!pend[FLAG_WK] && !ctl.wk_en) |=> !pend[FLAG_WK]);

endmodule

// File: tb/sec_alarm_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wk_hit_i = 1'b0, bus_wr_i = 1'b0;
  logic [7:0]  bus_addr_i = 8'h00;
  logic [31:0] bus_wdata_i = 32'h0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, wake_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model
  logic [31:0] m_cnt, m_ld;
  logic m_en, m_ie, m_pend, m_wake, m_wen, m_wie, m_wp;

  always #10 clk = ~clk;

  sec_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wk_hit_i(wk_hit_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr_i = a;
    #1;
    v = bus_rdata_o;
  endtask

  function automatic logic exp_irq();
    return (m_pend & m_ie) | (m_wp & m_wie);
  endfunction

  function automatic logic exp_wake();
    return m_pend & m_wake;
  endfunction

  task automatic model(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic t, input logic h);
    logic expd;
    logic wkset;
    expd  = 1'b0;
    wkset = h & m_wen;
    if (w && a == 8'h20) begin
      m_cnt = d; m_ld = d;
    end else if (m_en && t && m_cnt != 0) begin
      expd  = (m_cnt == 1);
      m_cnt = m_cnt - 1;
    end
    if (expd) m_pend = 1'b1;
    else if (w && a == 8'h30 && d[0]) m_pend = 1'b0;
    if (wkset) m_wp = 1'b1;
    else if (w && a == 8'h4C && d[0]) m_wp = 1'b0;
    if (w) begin
      case (a)
        8'h28: m_en   = d[0];
        8'h2C: m_ie   = d[0];
        8'h44: m_wen  = d[0];
        8'h48: m_wie  = d[0];
        8'h50: m_wake = d[0];
        default: ;
      endcase
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic t, input logic h);
    bus_wr_i = w; bus_addr_i = a; bus_wdata_i = d; tick_i = t; wk_hit_i = h;
    model(w, a, d, t, h);
    @(posedge clk);
    @(negedge clk);
    bus_wr_i = 1'b0; tick_i = 1'b0; wk_hit_i = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] v;
    rd(8'h24, v); chk({tag, " R3 left"}, v, m_cnt);
    rd(8'h30, v); chk({tag, " R4 pend"}, v, {31'h0, m_pend});
    rd(8'h4C, v); chk({tag, " R9 wkstat"}, v, {31'h0, m_wp});
    chk({tag, " R7 irq"}, {31'h0, irq_o}, {31'h0, exp_irq()});
    chk({tag, " R8 wake"}, {31'h0, wake_o}, {31'h0, exp_wake()});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    void'($urandom(32'h5EED_0A1A));
    m_cnt = 0; m_ld = 0; m_en = 0; m_ie = 0; m_pend = 0; m_wake = 0;
    m_wen = 0; m_wie = 0; m_wp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    foreach (sec_alarm_pkg::OFS_LOAD[i]) ; // no-op keeps loop vars local
    rd(8'h20, v); chk("R1 load", v, 0);
    rd(8'h24, v); chk("R1 left", v, 0);
    rd(8'h28, v); chk("R1 en", v, 0);
    rd(8'h2C, v); chk("R1 ie", v, 0);
    rd(8'h30, v); chk("R1 pend", v, 0);
    rd(8'h44, v); chk("R1 wen", v, 0);
    rd(8'h48, v); chk("R1 wie", v, 0);
    rd(8'h4C, v); chk("R1 wst", v, 0);
    rd(8'h50, v); chk("R1 wake cfg", v, 0);
    chk("R1 irq", {31'h0, irq_o}, 0);
    chk("R1 wake", {31'h0, wake_o}, 0);
    @(negedge clk);

    // R2 load and readback; write to 0x24 ignored
    step(1, 8'h20, 32'd3, 0, 0);
    rd(8'h20, v); chk("R2 load readback", v, 3);
    rd(8'h24, v); chk("R2 left", v, 3);
    step(1, 8'h24, 32'd9, 0, 0);
    rd(8'h24, v); chk("R2 left write ignored", v, 3);

    // R3 holding while disabled, then stepping
    step(0, 8'h00, 0, 1, 0);
    check_all("R3 disabled tick");
    step(1, 8'h28, 32'h1, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    check_all("R3 no tick");
    step(0, 8'h00, 0, 1, 0);
    rd(8'h24, v); chk("R3 one step", v, 2);

    // R10 load on a tick cycle
    step(1, 8'h20, 32'd5, 1, 0);
    rd(8'h24, v); chk("R10 load wins", v, 5);

    // R4 expiry and hold at zero
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 1, 0);
    rd(8'h30, v); chk("R4 pending set", v, 1);
    rd(8'h24, v); chk("R4 at zero", v, 0);
    step(0, 8'h00, 0, 1, 0);
    check_all("R4 hold zero");

    // R7 / R8 gating
    chk("R7 irq gated off", {31'h0, irq_o}, 0);
    chk("R8 wake gated off", {31'h0, wake_o}, 0);
    step(1, 8'h2C, 32'h1, 0, 0);
    chk("R7 irq on", {31'h0, irq_o}, 1);
    step(1, 8'h50, 32'h1, 0, 0);
    chk("R8 wake on", {31'h0, wake_o}, 1);

    // R6 W1C, zero write no effect, set beats clear
    step(1, 8'h30, 32'h0, 0, 0);
    rd(8'h30, v); chk("R6 zero write", v, 1);
    step(1, 8'h30, 32'h1, 0, 0);
    rd(8'h30, v); chk("R6 cleared", v, 0);
    chk("R7 irq drops", {31'h0, irq_o}, 0);
    step(1, 8'h20, 32'd1, 0, 0);
    step(1, 8'h30, 32'h1, 1, 0);
    rd(8'h30, v); chk("R6 set beats clear", v, 1);
    step(1, 8'h30, 32'h1, 0, 0);

    // R5 zero load and disable do not set pending
    step(1, 8'h20, 32'd2, 0, 0);
    step(0, 8'h00, 0, 1, 0);
    step(1, 8'h20, 32'd0, 0, 0);
    step(0, 8'h00, 0, 1, 0);
    rd(8'h30, v); chk("R5 zero load no pend", v, 0);
    step(1, 8'h20, 32'd1, 0, 0);
    step(1, 8'h28, 32'h0, 0, 0);
    step(0, 8'h00, 0, 1, 0);
    rd(8'h24, v); chk("R5 disabled holds", v, 1);
    rd(8'h30, v); chk("R5 disabled no pend", v, 0);

    // R9 weekly bits
    step(0, 8'h00, 0, 0, 1);
    rd(8'h4C, v); chk("R9 hit ignored when off", v, 0);
    step(1, 8'h44, 32'h1, 0, 0);
    step(0, 8'h00, 0, 0, 1);
    rd(8'h4C, v); chk("R9 hit sets", v, 1);
    chk("R9 no irq without ie", {31'h0, irq_o}, 0);
    step(1, 8'h48, 32'h1, 0, 0);
    chk("R7 weekly irq", {31'h0, irq_o}, 1);
    chk("R8 weekly no wake", {31'h0, wake_o}, 0);
    step(1, 8'h4C, 32'h1, 0, 0);
    rd(8'h4C, v); chk("R9 cleared", v, 0);

    // R11 only bit 0 stored; unmapped ignored
    step(1, 8'h2C, 32'hFFFF_FFFE, 0, 0);
    rd(8'h2C, v); chk("R11 upper bits dropped", v, 0);
    step(1, 8'h2C, 32'hFFFF_FFFF, 0, 0);
    rd(8'h2C, v); chk("R11 bit0 only", v, 1);
    step(1, 8'h34, 32'hFFFF_FFFF, 0, 0);
    rd(8'h34, v); chk("R11 unmapped reads 0", v, 0);
    check_all("R11 unmapped write");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      logic h;
      op = $urandom % 10;
      h  = ($urandom % 6) == 0;
      case (op)
        0, 1, 2, 3: step(0, 8'h00, 0, 1, h);
        4:          step(1, 8'h20, $urandom % 6, $urandom % 2, h);
        5:          step(1, 8'h28, $urandom, $urandom % 2, h);
        6:          step(1, 8'h30, $urandom, $urandom % 2, h);
        7:          step(1, 8'h2C, $urandom, 0, h);
        8:          step(1, 8'h50, $urandom, 1, h);
        default:    step(1, (($urandom % 2) == 0) ? 8'h4C : 8'h44, $urandom, 1, h);
      endcase
      check_all("rand");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule